// File: doc/BRIEF.md
# UART Register and Interrupt Controller

This block sits between a 32-bit register bus and the serial engines of a UART. Software writes bytes to a data register and they queue in an internal transmit FIFO. The transmit serializer drains that FIFO through a valid/take handshake. Bytes from the receive deserializer arrive through a strobe, queue in an internal receive FIFO, and are popped by reads of the same data register.

The block also holds the line control value and the baud divisor, and passes both to the serializer. It keeps a status byte with sticky error and event flags, some of which clear when software reads them. It reports FIFO fill state and the occupancy count of each queue. It raises one level interrupt, and that interrupt is gated by a mode bit.

A write of a magic value to the reset register returns every register and both FIFOs to their reset state. The same write gives the serializer a one-cycle abort so that any transmission in progress is dropped. Both FIFO depths are parameters.

Top module: `uart_reg_ctrl`

## Requirements
- R1: After reset, status (word 1, offset 0x04) reads 0x40, FIFO status (word 4, offset 0x10) reads 0x11, both occupancy counts (words 5 and 6) read 0, and irq is low.
- R2: A write to word 0 (offset 0x00) queues its low byte for transmit. The serializer sees the oldest byte on tx_byte while tx_valid is high, and each tx_take pops one byte. Word 5 reads the number of queued transmit bytes.
- R3: The write that fills the last transmit slot sets FIFO status bit 0x04 (TX full). A data write while the FIFO is full drops the byte and sets status bit 0x04 (overrun).
- R4: A read of word 0 pops the oldest received byte, and returns 0 when the receive FIFO is empty. Any data read after which the receive FIFO is empty clears the overrun bit, and FIFO status bit 0x10 (RX empty) is set.
- R5: Every rx_strobe sets status bit 0x80 (RX available). When the receive FIFO already holds RX_DEPTH bytes, the new byte is dropped and FIFO status bit 0x40 (RX full) reads 1.
- R6: A status read returns the current value, then clears bits 0x80 and 0x20. The other bits are left as they were.
- R7: Status bit 0x20 (TX complete) is set when a tx_take empties the transmit FIFO, and cleared by a data write into an empty transmit FIFO. Status bit 0x40 and FIFO status bit 0x01 read 1 while the transmit FIFO is empty.
- R8: irq is high exactly when mode bit 0x04 is set and at least one status bit out of 0x01, 0x02, 0x04, 0x08, 0x20 or 0x80 is set.
- R9: Writing a low byte of 0x55 to word 8 (offset 0x20) empties both FIFOs, restores every reset value and pulses tx_abort during that write. Any other value is only stored and reads back from word 8.
- R10: A write of a nonzero value to word 3 (offset 0x0C) sets the divisor on ser_div. A write of zero is ignored.
- R11: A write to word 2 (offset 0x08, mode) with bit 0x20 clear makes the receive FIFO refuse new bytes until the next reset, even if bit 0x20 is set again later.
- R12: line_err bits 0, 1 and 2 set status bits 0x01 (parity), 0x02 (framing) and 0x08 (break). These bits stay set until reset.
- R13: Reads of undefined words (7 and 9 to 15) return 0, and writes to them change nothing.
- R14: A write to word 1 drives its low byte onto ser_ctrl. A read of word 1 returns status, not this value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_word | input | 4 | Word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| ser_ctrl | output | 8 | Line control value for the serializer |
| ser_div | output | 32 | Baud divisor |
| tx_valid | output | 1 | Transmit FIFO not empty |
| tx_byte | output | 8 | Oldest transmit byte |
| tx_take | input | 1 | Serializer pops one transmit byte |
| tx_abort | output | 1 | Cancel current transmission (soft reset) |
| rx_strobe | input | 1 | Received byte present |
| rx_byte | input | 8 | Received byte |
| line_err | input | 3 | Parity, framing and break error pulses |
| irq | output | 1 | Level interrupt |

## Verification
On every cycle the assertions check several properties. The transmit count never exceeds its depth. A dropped write sets overrun. A receive strobe and a final transmit pop each set their event flag one cycle later. A status read clears RX available. irq stays low whenever mode bit 0x04 is clear. A soft reset empties both queues, and a zero divisor write leaves ser_div unchanged. Only the bench scenarios can show the byte order through each FIFO and the read-then-clear value a status read returns. They also show the latched receive refusal surviving a later mode write, the sticky error bits, and the restored state after the magic write.

// File: rtl/uart_reg_pkg.sv
package uart_reg_pkg;

  // word indexes on the register bus
  localparam logic [3:0] W_DATA  = 4'd0;
  localparam logic [3:0] W_CTSTA = 4'd1;
  localparam logic [3:0] W_MODE  = 4'd2;
  localparam logic [3:0] W_DIV   = 4'd3;
  localparam logic [3:0] W_FSTAT = 4'd4;
  localparam logic [3:0] W_TXCNT = 4'd5;
  localparam logic [3:0] W_RXCNT = 4'd6;
  localparam logic [3:0] W_SRST  = 4'd8;

  // status bit positions
  localparam int S_PAR  = 0;
  localparam int S_FRM  = 1;
  localparam int S_OVR  = 2;
  localparam int S_BRK  = 3;
  localparam int S_TDONE = 5;
  localparam int S_TEMPTY = 6;
  localparam int S_RAVAIL = 7;

  // mode bit positions
  localparam int M_IRQ_EN = 2;
  localparam int M_RX_EN  = 5;

  localparam logic [7:0] SRST_KEY = 8'h55;

  // status bits that may raise the interrupt
  localparam logic [7:0] IRQ_MASK = 8'hAF;

  function automatic logic irq_level(input logic [7:0] stat, input logic [7:0] mode);
    return mode[M_IRQ_EN] && ((stat & IRQ_MASK) != 8'h00);
  endfunction

  function automatic logic [7:0] fifo_flags(input logic tx_e, input logic tx_f,
                                            input logic rx_e, input logic rx_f);
    return {1'b0, rx_f, 1'b0, rx_e, 1'b0, tx_f, 1'b0, tx_e};
  endfunction

  // count left after one cycle of optional push and pop
  function automatic logic drains_to_zero(input logic one_left, input logic zero_now,
                                          input logic pop_ok, input logic push_ok);
    return !push_ok && (zero_now || (one_left && pop_ok));
  endfunction

endpackage

// File: rtl/uart_reg_fifo.sv
module uart_reg_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CW-1:0]    count,
  output logic             empty,
  output logic             full,
  output logic             push_ok,
  output logic             pop_ok
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      if (push_ok && !pop_ok)      count <= count + CW'(1);
      else if (pop_ok && !push_ok) count <= count - CW'(1);
    end
  end

endmodule

// File: rtl/uart_reg_status.sv
module uart_reg_status
  import uart_reg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       stat_rd,
  input  logic [2:0] err_in,
  input  logic       tx_ovf,
  input  logic       tx_done,
  input  logic       tx_restart,
  input  logic       rx_arrive,
  input  logic       rx_drained,
  output logic [7:0] status_q
);

  logic [7:0] nxt;

  always_comb begin
    nxt = status_q;
    if (stat_rd) begin
      nxt[S_RAVAIL] = 1'b0;
      nxt[S_TDONE]  = 1'b0;
    end
    if (tx_restart) nxt[S_TDONE] = 1'b0;
    if (tx_done)    nxt[S_TDONE] = 1'b1;
    if (rx_arrive)  nxt[S_RAVAIL] = 1'b1;
    if (err_in[0])  nxt[S_PAR] = 1'b1;
    if (err_in[1])  nxt[S_FRM] = 1'b1;
    if (err_in[2])  nxt[S_BRK] = 1'b1;
    if (rx_drained) nxt[S_OVR] = 1'b0;
    if (tx_ovf)     nxt[S_OVR] = 1'b1;
    nxt[S_TEMPTY] = 1'b0;
    nxt[4] = 1'b0;
    if (clr) nxt = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= nxt;
  end

endmodule

// File: rtl/uart_reg_ctrl.sv
module uart_reg_ctrl
  import uart_reg_pkg::*;
#(
  parameter int TX_DEPTH = 16,
  parameter int RX_DEPTH = 8,
  localparam int TX_CW = $clog2(TX_DEPTH + 1),
  localparam int RX_CW = $clog2(RX_DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [3:0]  bus_word,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic [7:0]  ser_ctrl,
  output logic [31:0] ser_div,
  output logic        tx_valid,
  output logic [7:0]  tx_byte,
  input  logic        tx_take,
  output logic        tx_abort,
  input  logic        rx_strobe,
  input  logic [7:0]  rx_byte,
  input  logic [2:0]  line_err,
  output logic        irq
);

  logic [7:0]  mode_q, rst_reg_q;
  logic        rx_gate_q;
  logic [7:0]  status_q, status_view;
  logic [TX_CW-1:0] tx_cnt;
  logic [RX_CW-1:0] rx_cnt;
  logic [7:0]  rx_head;
  logic        tx_empty, tx_full, rx_empty, rx_full;
  logic        tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok;

  // named bus events
  logic bus_w, bus_r;
  logic ev_tx_wr, ev_rx_rd, ev_stat_rd, ev_srst, ev_div_zero, ev_mode_wr;
  logic ev_tx_ovf, ev_tx_done, ev_tx_restart, ev_rx_arrive, ev_rx_drained;

  assign bus_w = bus_sel && bus_wr;
  assign bus_r = bus_sel && !bus_wr;

  assign ev_tx_wr    = bus_w && (bus_word == W_DATA);
  assign ev_rx_rd    = bus_r && (bus_word == W_DATA);
  assign ev_stat_rd  = bus_r && (bus_word == W_CTSTA);
  assign ev_mode_wr  = bus_w && (bus_word == W_MODE);
  assign ev_srst     = bus_w && (bus_word == W_SRST) && (bus_wdata[7:0] == SRST_KEY);
  assign ev_div_zero = bus_w && (bus_word == W_DIV) && (bus_wdata == 32'd0);

  assign ev_tx_ovf     = ev_tx_wr && tx_full;
  assign ev_tx_restart = tx_push_ok && tx_empty;
  assign ev_tx_done    = tx_pop_ok &&
                         drains_to_zero(tx_cnt == TX_CW'(1), 1'b0, tx_pop_ok, tx_push_ok);
  assign ev_rx_arrive  = rx_strobe;
  assign ev_rx_drained = ev_rx_rd &&
                         drains_to_zero(rx_cnt == RX_CW'(1), rx_empty, rx_pop_ok, rx_push_ok);

  assign tx_abort = ev_srst;

  uart_reg_fifo #(.WIDTH(8), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(ev_srst),
    .push(ev_tx_wr), .push_data(bus_wdata[7:0]),
    .pop(tx_take), .head(tx_byte), .count(tx_cnt),
    .empty(tx_empty), .full(tx_full),
    .push_ok(tx_push_ok), .pop_ok(tx_pop_ok)
  );

  uart_reg_fifo #(.WIDTH(8), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(ev_srst),
    .push(rx_strobe && rx_gate_q), .push_data(rx_byte),
    .pop(ev_rx_rd), .head(rx_head), .count(rx_cnt),
    .empty(rx_empty), .full(rx_full),
    .push_ok(rx_push_ok), .pop_ok(rx_pop_ok)
  );

  uart_reg_status u_stat (
    .clk(clk), .rst_n(rst_n), .clr(ev_srst),
    .stat_rd(ev_stat_rd), .err_in(line_err),
    .tx_ovf(ev_tx_ovf), .tx_done(ev_tx_done), .tx_restart(ev_tx_restart),
    .rx_arrive(ev_rx_arrive), .rx_drained(ev_rx_drained),
    .status_q(status_q)
  );

  assign tx_valid = !tx_empty;

  always_comb begin
    status_view = status_q;
    status_view[S_TEMPTY] = tx_empty;
  end

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ser_ctrl  <= '0;
      mode_q    <= '0;
      ser_div   <= '0;
      rst_reg_q <= '0;
      rx_gate_q <= 1'b1;
    end else if (ev_srst) begin
      ser_ctrl  <= '0;
      mode_q    <= '0;
      ser_div   <= '0;
      rst_reg_q <= '0;
      rx_gate_q <= 1'b1;
    end else if (bus_w) begin
      case (bus_word)
        W_CTSTA: ser_ctrl <= bus_wdata[7:0];
        W_MODE: begin
          mode_q <= bus_wdata[7:0];
          if (!bus_wdata[M_RX_EN]) rx_gate_q <= 1'b0;
        end
        W_DIV:  if (!ev_div_zero) ser_div <= bus_wdata;
        W_SRST: rst_reg_q <= bus_wdata[7:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_r) begin
      case (bus_word)
        W_DATA:  bus_rdata = rx_empty ? 32'd0 : {24'd0, rx_head};
        W_CTSTA: bus_rdata = {24'd0, status_view};
        W_MODE:  bus_rdata = {24'd0, mode_q};
        W_DIV:   bus_rdata = ser_div;
        W_FSTAT: bus_rdata = {24'd0, fifo_flags(tx_empty, tx_full, rx_empty, rx_full)};
        W_TXCNT: bus_rdata = 32'(tx_cnt);
        W_RXCNT: bus_rdata = 32'(rx_cnt);
        W_SRST:  bus_rdata = {24'd0, rst_reg_q};
        default: bus_rdata = '0;
      endcase
    end
  end

  assign irq = irq_level(status_q, mode_q);

endmodule

// File: rtl/uart_reg_ctrl_chk.sv
module uart_reg_ctrl_chk #(
  parameter int TX_DEPTH = 16,
  parameter int RX_DEPTH = 8,
  localparam int TX_CW = $clog2(TX_DEPTH + 1),
  localparam int RX_CW = $clog2(RX_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic [7:0]       mode_q,
  input logic [7:0]       status_q,
  input logic [TX_CW-1:0] tx_cnt,
  input logic [RX_CW-1:0] rx_cnt,
  input logic [31:0]      ser_div,
  input logic             ev_tx_ovf,
  input logic             ev_tx_done,
  input logic             ev_rx_arrive,
  input logic             ev_stat_rd,
  input logic             ev_srst,
  input logic             ev_div_zero
);

  assert_tx_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= TX_CW'(TX_DEPTH));

  assert_rx_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= RX_CW'(RX_DEPTH));

  assert_ovf_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_tx_ovf && !ev_srst) |=> status_q[2]);

  assert_rx_seen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx_arrive && !ev_srst) |=> status_q[7]);

  assert_rd_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stat_rd && !ev_rx_arrive) |=> !status_q[7]);

  assert_tdone_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_tx_done && !ev_srst) |=> status_q[5]);

  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q[2] |-> !irq);

  assert_srst_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_srst |=> (tx_cnt == '0 && rx_cnt == '0 && status_q == 8'h00));

  assert_div_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_div_zero |=> $stable(ser_div));

endmodule

bind uart_reg_ctrl uart_reg_ctrl_chk #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .mode_q(mode_q), .status_q(status_q),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .ser_div(ser_div),
  .ev_tx_ovf(ev_tx_ovf), .ev_tx_done(ev_tx_done), .ev_rx_arrive(ev_rx_arrive),
  .ev_stat_rd(ev_stat_rd), .ev_srst(ev_srst), .ev_div_zero(ev_div_zero)
);

// File: tb/test_uart_reg_ctrl.sv
module test_uart_reg_ctrl;

  localparam int TXD = 16;
  localparam int RXD = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0] bus_word = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [7:0] ser_ctrl, tx_byte, rx_byte = '0;
  logic [31:0] ser_div;
  logic tx_valid, tx_take = 1'b0, tx_abort, rx_strobe = 1'b0, irq;
  logic [2:0] line_err = '0;

  int checks = 0;
  int errors = 0;
  logic [31:0] rd;

  always #2.5 clk = ~clk;

  uart_reg_ctrl #(.TX_DEPTH(TXD), .RX_DEPTH(RXD)) i_uart_reg_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ser_ctrl(ser_ctrl), .ser_div(ser_div), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .tx_take(tx_take), .tx_abort(tx_abort), .rx_strobe(rx_strobe), .rx_byte(rx_byte),
    .line_err(line_err), .irq(irq)
  );

  // {write, byte offset, data, expected read}
  localparam logic [72:0] VEC [0:13] = '{
    {1'b0, 8'h04, 32'h0,     32'h40},    // R1
    {1'b0, 8'h10, 32'h0,     32'h11},    // R1
    {1'b0, 8'h14, 32'h0,     32'h0},     // R1
    {1'b0, 8'h18, 32'h0,     32'h0},     // R1
    {1'b1, 8'h0C, 32'h1A0,   32'h0},
    {1'b0, 8'h0C, 32'h0,     32'h1A0},   // R10
    {1'b1, 8'h0C, 32'h0,     32'h0},
    {1'b0, 8'h0C, 32'h0,     32'h1A0},   // R10 zero ignored
    {1'b1, 8'h1C, 32'hAB,    32'h0},
    {1'b0, 8'h1C, 32'h0,     32'h0},     // R13
    {1'b1, 8'h04, 32'h0B,    32'h0},
    {1'b0, 8'h04, 32'h0,     32'h40},    // R14 status, not ctrl
    {1'b1, 8'h20, 32'h12,    32'h0},
    {1'b0, 8'h20, 32'h0,     32'h12}     // R9 non-key stored
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] off, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_word = off[5:2]; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rdv(input logic [7:0] off, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_word = off[5:2];
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 1'b0;
  endtask

  task automatic rdc(input string req, input logic [7:0] off, input logic [31:0] exp);
    logic [31:0] v;
    rdv(off, v);
    check(req, v, exp);
  endtask

  task automatic take();
    @(negedge clk); tx_take = 1'b1;
    @(posedge clk); #1; tx_take = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk); rx_strobe = 1'b1; rx_byte = b;
    @(posedge clk); #1; rx_strobe = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got 0x0 expected 0x1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    settle();
    check("R1 irq", {31'd0, irq}, 32'd0);

    for (int i = 0; i < 14; i++) begin
      if (VEC[i][72]) wr(VEC[i][71:64], VEC[i][63:32]);
      else rdc("table R1/R9/R10/R13/R14", VEC[i][71:64], VEC[i][31:0]);
    end
    settle();
    check("R14 ser_ctrl", {24'd0, ser_ctrl}, 32'h0B);
    check("R10 ser_div", ser_div, 32'h1A0);

    wr(8'h08, 32'h24);
    rdc("R11 mode readback", 8'h08, 32'h24);

    // R2 / R7 transmit path
    wr(8'h00, 32'h31); wr(8'h00, 32'h32); wr(8'h00, 32'h33);
    settle();
    check("R2 tx_valid", {31'd0, tx_valid}, 32'd1);
    check("R2 head", {24'd0, tx_byte}, 32'h31);
    rdc("R2 tx count", 8'h14, 32'd3);
    rdc("R7 status busy", 8'h04, 32'h00);
    take(); settle();
    check("R2 order", {24'd0, tx_byte}, 32'h32);
    take(); take(); settle();
    check("R8 irq on done", {31'd0, irq}, 32'd1);
    rdc("R7 done+empty", 8'h04, 32'h60);
    rdc("R6 cleared", 8'h04, 32'h40);
    settle();
    check("R8 irq low", {31'd0, irq}, 32'd0);

    // R3 transmit full and overrun
    for (int i = 0; i < TXD; i++) wr(8'h00, 32'h40 + i);
    rdc("R3 tx full flag", 8'h10, 32'h14);
    wr(8'h00, 32'h99);
    rdc("R3 count kept", 8'h14, TXD);
    settle();
    check("R8 irq on overrun", {31'd0, irq}, 32'd1);
    rdc("R3 overrun", 8'h04, 32'h04);
    for (int i = 0; i < TXD; i++) begin
      settle();
      check("R2 drain order", {24'd0, tx_byte}, 32'h40 + i);
      take();
    end
    rdc("R7 after drain", 8'h04, 32'h64);
    rdc("R6 keeps overrun", 8'h04, 32'h44);

    // R4 empty read
    rdc("R4 empty data", 8'h00, 32'h0);
    rdc("R4 overrun cleared", 8'h04, 32'h40);

    // R4 / R5 receive path
    push(8'hA1); push(8'hA2);
    rdc("R5 rx avail", 8'h04, 32'hC0);
    rdc("R4 first", 8'h00, 32'hA1);
    rdc("R4 count", 8'h18, 32'd1);
    rdc("R4 second", 8'h00, 32'hA2);
    rdc("R4 rx empty flag", 8'h10, 32'h11);

    for (int i = 0; i < RXD + 1; i++) push(8'hB0 + 8'(i));
    rdc("R5 count capped", 8'h18, RXD);
    rdc("R5 rx full flag", 8'h10, 32'h41);
    for (int i = 0; i < RXD; i++) rdc("R4 rx order", 8'h00, 32'hB0 + i);
    rdc("R5 avail after drop", 8'h04, 32'hC0);

    // R12 / R8 errors and gating
    @(negedge clk); line_err = 3'b001;
    @(posedge clk); #1; line_err = '0;
    settle();
    check("R8 irq on parity", {31'd0, irq}, 32'd1);
    wr(8'h08, 32'h20);
    settle();
    check("R8 gated", {31'd0, irq}, 32'd0);
    wr(8'h08, 32'h24);
    rdc("R12 sticky", 8'h04, 32'h41);
    rdc("R12 still", 8'h04, 32'h41);
    @(negedge clk); line_err = 3'b110;
    @(posedge clk); #1; line_err = '0;
    rdc("R12 framing+break", 8'h04, 32'h4B);

    // R11 receive refusal latch
    wr(8'h08, 32'h04);
    push(8'hCC);
    rdc("R11 refused", 8'h18, 32'd0);
    rdc("R11 avail still", 8'h04, 32'hCB);
    wr(8'h08, 32'h24);
    push(8'hCD);
    rdc("R11 latched", 8'h18, 32'd0);

    // R9 magic reset
    wr(8'h00, 32'h77); wr(8'h00, 32'h78);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_word = 4'd8; bus_wdata = 32'h55;
    #1 check("R9 tx_abort", {31'd0, tx_abort}, 32'd1);
    @(posedge clk); #1; bus_sel = 1'b0; bus_wr = 1'b0;
    settle();
    check("R9 tx_valid", {31'd0, tx_valid}, 32'd0);
    check("R9 irq", {31'd0, irq}, 32'd0);
    check("R9 div", ser_div, 32'd0);
    rdc("R9 status", 8'h04, 32'h40);
    rdc("R9 fifo flags", 8'h10, 32'h11);
    rdc("R9 tx count", 8'h14, 32'd0);
    rdc("R9 reg value", 8'h20, 32'd0);
    rdc("R9 mode", 8'h08, 32'd0);
    push(8'hDD);
    rdc("R11 reopened", 8'h18, 32'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule